// File: doc/BRIEF.md
# Ping-pong pipe bank tracker

This block follows the buffer state of one host pipe whose data lives in one or two banks used alternately. It counts how many banks are busy, keeps a pointer to the bank that software works on next, and reports whether software may touch that bank now. A bank is busy when it holds data not yet consumed. On an OUT pipe, software fills banks and the transfer engine drains them. On an IN pipe, the engine fills banks with data from the device and software drains them.

The block raises a bank interrupt when its enable is set. On an OUT pipe it fires when every configured bank is busy. On an IN pipe it fires when every bank is free. It also holds a sticky error flag for buffer reads that underflow during an IN data stage. Software clears that flag by writing one to a clear strobe. Direction, pipe type and the bank mode are static configuration. They change only while reset is held.

Top module: `pipe_bank_tracker`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears all outputs to zero: `cur_bank` 00, `busy_cnt` 00, `ram_err` 0. With `pipe_in` low, `rw_ok` is 1. With `pipe_in` high, `rw_ok` is 0.
- R2: `busy_cnt` encodes free/one/two busy banks as 00/01/10. It never shows 11, and it never exceeds the bank limit (1 when `dual_bank`=0, 2 when `dual_bank`=1).
- R3: OUT pipe (`pipe_in`=0): `sw_done` while `rw_ok` is high adds one busy bank, and `eng_done` while `busy_cnt`>0 removes one. Any other strobe is ignored, and the count changes on the following edge.
- R4: IN pipe (`pipe_in`=1): `eng_done` while `busy_cnt` is below the limit adds one busy bank, and `sw_done` while `rw_ok` is high removes one. Any other strobe is ignored.
- R5: When the software strobe and the engine strobe are both accepted in the same cycle, `busy_cnt` is unchanged.
- R6: `rw_ok` is high when software may use the current bank. On an OUT pipe that means `busy_cnt` is below the limit. On an IN pipe it means `busy_cnt`>0. A `sw_done` while `rw_ok` is low has no effect.
- R7: On a non-control pipe in dual-bank mode, every accepted `sw_done` toggles `cur_bank` between 00 and 01 on the second edge after the strobe. `cur_bank` therefore trails the `rw_ok`/`busy_cnt` update by exactly one cycle.
- R8: When `pipe_ctrl`=1 or `dual_bank`=0, `cur_bank` is 00.
- R9: `bank_int` is `bank_int_en` AND (`busy_cnt` equals the limit) on an OUT pipe. On an IN pipe it is `bank_int_en` AND (`busy_cnt`=0).
- R10: `ram_underflow` on an IN pipe sets `ram_err` on the next edge. The flag stays set until `err_clr` is high at an edge, and a set wins over a clear in the same cycle. On an OUT pipe, `ram_underflow` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pipe_in | input | 1 | 1 = IN pipe, 0 = OUT pipe |
| pipe_ctrl | input | 1 | 1 = control pipe |
| dual_bank | input | 1 | 1 = two banks, 0 = one bank |
| sw_done | input | 1 | Software has filled (OUT) or read (IN) the current bank |
| eng_done | input | 1 | Engine has sent (OUT) or received (IN) a bank |
| bank_int_en | input | 1 | Bank interrupt enable |
| ram_underflow | input | 1 | Buffer read underflow during IN data stage |
| err_clr | input | 1 | Write-one clear of `ram_err` |
| cur_bank | output | 2 | Current bank: 00 bank 0, 01 bank 1 |
| busy_cnt | output | 2 | Number of busy banks |
| rw_ok | output | 1 | Current bank available to software |
| bank_int | output | 1 | Direction-dependent bank interrupt |
| ram_err | output | 1 | Sticky underflow error flag |

## Verification
The hardest state to reach from the ports is a cycle in which both strobes are accepted together. That needs a count strictly between empty and full, which exists only in dual-bank mode with exactly one bank busy. In that state the pointer also toggles while the count stays put. The bench runs long random strobe streams in all eight combinations of direction, pipe type and bank mode, with both strobes frequent, so that the one-busy state recurs. A directed sequence then forces the same collision, along with a set and clear of the error flag in the same cycle.

// File: rtl/pipe_bank_tracker.sv
module pipe_bank_tracker (
  input  logic       clk,
  input  logic       rst,
  input  logic       pipe_in,
  input  logic       pipe_ctrl,
  input  logic       dual_bank,
  input  logic       sw_done,
  input  logic       eng_done,
  input  logic       bank_int_en,
  input  logic       ram_underflow,
  input  logic       err_clr,
  output logic [1:0] cur_bank,
  output logic [1:0] busy_cnt,
  output logic       rw_ok,
  output logic       bank_int,
  output logic       ram_err
);

  logic [1:0] lim;
  logic [1:0] busy_q;
  logic       sw_acc, eng_acc, inc, dec;
  logic       sw_acc_q, bank_q, err_q;

  assign lim     = dual_bank ? 2'd2 : 2'd1;
  assign rw_ok   = pipe_in ? (busy_q != 2'd0) : (busy_q < lim);
  assign sw_acc  = sw_done && rw_ok;
  assign eng_acc = eng_done && (pipe_in ? (busy_q < lim) : (busy_q != 2'd0));
  assign inc     = pipe_in ? eng_acc : sw_acc;
  assign dec     = pipe_in ? sw_acc : eng_acc;

  always_ff @(posedge clk) begin
    if (rst)
      busy_q <= 2'd0;
    else if (inc && !dec)
      busy_q <= busy_q + 2'd1;
    else if (dec && !inc)
      busy_q <= busy_q - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_acc_q <= 1'b0;
      bank_q   <= 1'b0;
    end else begin
      sw_acc_q <= sw_acc;
      if (pipe_ctrl || !dual_bank)
        bank_q <= 1'b0;
      else if (sw_acc_q)
        bank_q <= ~bank_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      err_q <= 1'b0;
    else if (ram_underflow && pipe_in)
      err_q <= 1'b1;
    else if (err_clr)
      err_q <= 1'b0;
  end

  assign cur_bank = {1'b0, bank_q};
  assign busy_cnt = busy_q;
  assign ram_err  = err_q;
  assign bank_int = bank_int_en && (pipe_in ? (busy_q == 2'd0) : (busy_q == lim));

  p_busy_legal_r2: assert property (@(posedge clk) disable iff (rst)
    busy_cnt != 2'b11);

  p_out_fill_r3: assert property (@(posedge clk) disable iff (rst)
    !pipe_in && sw_acc && !eng_acc |=> busy_cnt == $past(busy_cnt) + 2'd1);

  p_in_fill_r4: assert property (@(posedge clk) disable iff (rst)
    pipe_in && eng_acc && !sw_acc |=> busy_cnt == $past(busy_cnt) + 2'd1);

  p_cancel_r5: assert property (@(posedge clk) disable iff (rst)
    sw_acc && eng_acc |=> $stable(busy_cnt));

  p_blocked_sw_r6: assert property (@(posedge clk) disable iff (rst)
    sw_done && !rw_ok && !eng_done |=> $stable(busy_cnt));

  p_bank_lag_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(sw_acc) && dual_bank && !pipe_ctrl &&
    $past(dual_bank && !pipe_ctrl) |=> cur_bank != $past(cur_bank));

  p_bank_zero_r8: assert property (@(posedge clk) disable iff (rst)
    pipe_ctrl || !dual_bank |=> cur_bank == 2'b00);

  p_err_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ram_err && !err_clr |=> ram_err);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (rst)
    err_clr && !(ram_underflow && pipe_in) |=> !ram_err);

endmodule

// File: tb/test_pipe_bank_tracker.sv
`timescale 1ns/1ps
module test_pipe_bank_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pipe_in = 1'b0, pipe_ctrl = 1'b0, dual_bank = 1'b0;
  logic sw_done = 1'b0, eng_done = 1'b0, bank_int_en = 1'b0;
  logic ram_underflow = 1'b0, err_clr = 1'b0;
  logic [1:0] cur_bank, busy_cnt;
  logic rw_ok, bank_int, ram_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0] m_busy;
  logic m_bank, m_saq, m_err;
  string busy_tag;

  always #4 clk = ~clk;

  pipe_bank_tracker i_pipe_bank_tracker (
    .clk(clk), .rst(rst), .pipe_in(pipe_in), .pipe_ctrl(pipe_ctrl),
    .dual_bank(dual_bank), .sw_done(sw_done), .eng_done(eng_done),
    .bank_int_en(bank_int_en), .ram_underflow(ram_underflow),
    .err_clr(err_clr), .cur_bank(cur_bank), .busy_cnt(busy_cnt),
    .rw_ok(rw_ok), .bank_int(bank_int), .ram_err(ram_err));

  function automatic logic [1:0] f_lim(logic dual);
    return dual ? 2'd2 : 2'd1;
  endfunction

  function automatic logic f_rw(logic din, logic dual, logic [1:0] b);
    return din ? (b != 2'd0) : (b < f_lim(dual));
  endfunction

  function automatic logic f_int(logic en, logic din, logic dual, logic [1:0] b);
    return en && (din ? (b == 2'd0) : (b == f_lim(dual)));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sw_done = 0; eng_done = 0; ram_underflow = 0; err_clr = 0; bank_int_en = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_busy = 2'd0; m_bank = 1'b0; m_saq = 1'b0; m_err = 1'b0;
    busy_tag = "R1";
    #1;
    check(cur_bank == 2'b00, "R1 cur_bank", cur_bank, 0);
    check(busy_cnt == 2'b00, "R1 busy_cnt", busy_cnt, 0);
    check(ram_err == 1'b0, "R1 ram_err", ram_err, 0);
    check(rw_ok == !pipe_in, "R1 rw_ok", rw_ok, !pipe_in);
  endtask

  task automatic step(logic sw, logic eng, logic udf, logic clr, logic en);
    logic sa, ea, inc, dec;
    sw_done = sw; eng_done = eng; ram_underflow = udf; err_clr = clr; bank_int_en = en;
    #1;
    check(busy_cnt == m_busy, busy_tag, busy_cnt, m_busy);
    check(busy_cnt != 2'b11 && busy_cnt <= f_lim(dual_bank), "R2 busy limit", busy_cnt, f_lim(dual_bank));
    check(cur_bank == {1'b0, m_bank}, (pipe_ctrl || !dual_bank) ? "R8 cur_bank" : "R7 cur_bank", cur_bank, m_bank);
    check(rw_ok == f_rw(pipe_in, dual_bank, m_busy), "R6 rw_ok", rw_ok, f_rw(pipe_in, dual_bank, m_busy));
    check(bank_int == f_int(en, pipe_in, dual_bank, m_busy), "R9 bank_int", bank_int, f_int(en, pipe_in, dual_bank, m_busy));
    check(ram_err == m_err, "R10 ram_err", ram_err, m_err);
    sa = sw && f_rw(pipe_in, dual_bank, m_busy);
    ea = eng && (pipe_in ? (m_busy < f_lim(dual_bank)) : (m_busy != 2'd0));
    inc = pipe_in ? ea : sa;
    dec = pipe_in ? sa : ea;
    busy_tag = (sa && ea) ? "R5 busy_cnt" : (pipe_in ? "R4 busy_cnt" : "R3 busy_cnt");
    if (inc && !dec) m_busy = m_busy + 2'd1;
    else if (dec && !inc) m_busy = m_busy - 2'd1;
    if (pipe_ctrl || !dual_bank) m_bank = 1'b0;
    else if (m_saq) m_bank = ~m_bank;
    m_saq = sa;
    if (udf && pipe_in) m_err = 1'b1;
    else if (clr) m_err = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    for (int ph = 0; ph < 8; ph++) begin
      pipe_in = ph[0]; pipe_ctrl = ph[1]; dual_bank = ph[2];
      do_reset();
      for (int k = 0; k < 400; k++)
        step($urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 15) == 0, $urandom_range(0, 7) == 0,
             $urandom_range(0, 1));
    end
    // directed: OUT dual, reach one busy bank, then collide both strobes
    pipe_in = 0; pipe_ctrl = 0; dual_bank = 1;
    do_reset();
    step(1, 0, 0, 0, 1);
    step(1, 1, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    // directed: IN dual, error set and clear together, then clear alone
    pipe_in = 1;
    do_reset();
    step(0, 1, 1, 1, 1);
    step(1, 1, 0, 0, 1);
    step(0, 0, 0, 1, 1);
    step(1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 1);
    step(0, 0, 0, 0, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule